// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed burst mode into the stream of column addresses that an SDRAM controller issues during a read or write burst. A mode-set strobe stores a 13-bit operand that selects burst length, address order, CAS latency and a write-single option. A start strobe begins a burst at a given 8-bit column, marked as a read or a write. From the next clock the block presents one column address per cycle, with a valid flag and a last-beat flag, until the burst ends or a stop strobe cuts it short.

Sequential bursts count upward through the low column bits and wrap inside the aligned block the burst length defines. Interleaved bursts XOR the low bits of the start column with the beat index. A full-page mode walks all 256 columns sequentially from the start column. Operand codes the block cannot honour raise an error flag, and such bursts run as a single beat. The block moves no data. It only sequences addresses.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset the stored mode is all zeros, so bursts are 1 beat long, sequential, and not write-single. A mode-set strobe stores the operand at that clock edge. The new mode governs bursts that start on later cycles.
- R2: Operand bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page of 256 beats.
- R3: With operand bit 3 at 0, the order is sequential. Beat i has address (start & ~(L-1)) | ((start + i) & (L-1)).
- R4: With operand bit 3 at 1 and length L of 8 or less, beat i has address (start & ~(L-1)) | ((start ^ i) & (L-1)).
- R5: colValid rises in the cycle after the start strobe. One address is presented per cycle. colLast is high only on the final beat. colValid is low in the cycle after the final beat unless a new start was given.
- R6: With operand bit 9 at 1, a write burst is a single beat. Read bursts still use the programmed length.
- R7: A stop strobe with no start strobe in the same cycle makes colValid low from the next cycle, for any burst length.
- R8: A start strobe during an active burst abandons the old burst. The new burst's first address appears on the next cycle. A start strobe takes priority over a stop strobe in the same cycle.
- R9: cfgError is high while the stored length code is 100, 101 or 110, or while the code is 111 with bit 3 at 1. Bursts started in that state are 1 beat at the start column.
- R10: casLatency shows 2 when stored bits [6:4] are 010 and 3 when they are 011. Every other value shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| modeSetStb | input | 1 | Stores modeOperand as the burst mode |
| modeOperand | input | 13 | Mode operand: [2:0] length, [3] order, [6:4] latency, [9] write-single |
| startStb | input | 1 | Starts a burst at startCol |
| startIsWrite | input | 1 | 1 when the started burst is a write |
| startCol | input | 8 | First column of the burst |
| stopStb | input | 1 | Ends the active burst |
| colAddr | output | 8 | Current burst column address |
| colValid | output | 1 | colAddr holds a burst beat |
| colLast | output | 1 | Current beat is the final one |
| cfgError | output | 1 | Stored length and order combination is unusable |
| casLatency | output | 2 | Decoded CAS latency, 0 when reserved |

## Verification
Assertions check the following on every cycle:
- colValid follows every start strobe.
- colLast never appears without colValid.
- A stop, or a final beat with no restart, clears colValid on the next cycle.
- Write-single and error-mode starts produce a single last beat.
- The upper column bits hold steady while a burst steps.
- Sequential steps advance by one modulo the block.

The order of a whole burst can only be shown by the bench's scenarios, which compare every beat with a queue-based model. These scenarios cover interleave, wrap at the block edge, the 256-beat page wrap past column 255, restart mid-burst, and mode changes between bursts.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  // Strobes from control to the address datapath
  typedef struct packed {
    logic load;        // capture start column and burst shape
    logic step;        // advance to the next beat
    logic interleave;  // XOR ordering for the burst being loaded
  } colStrobes_t;

  // Length codes held in operand bits [2:0]
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } lenCode_e;

endpackage

// File: rtl/sdram_colgen_ctrl.sv
module sdram_colgen_ctrl
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int OP_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSetStb,
  input  logic [OP_W-1:0]  modeOperand,
  input  logic             startStb,
  input  logic             startIsWrite,
  input  logic             stopStb,
  output colStrobes_t      strb,
  output logic [COL_W-1:0] lenMask,
  output logic             colValid,
  output logic             colLast,
  output logic             cfgError,
  output logic [1:0]       casLatency
);

  localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};
  localparam int ILV_BIT    = 3;
  localparam int WSINGLE_BIT = 9;

  logic [OP_W-1:0]  modeReg;
  logic [COL_W-1:0] progMask;
  logic [COL_W-1:0] effMask;
  logic [COL_W-1:0] remain;
  logic             active;
  logic             lenErr;
  logic             ilvBit;
  logic             wSingle;
  logic [2:0]       clCode;

  assign ilvBit  = modeReg[ILV_BIT];
  assign wSingle = modeReg[WSINGLE_BIT];
  assign clCode  = modeReg[6:4];

  always_comb begin
    progMask = '0;
    lenErr   = 1'b0;
    case (lenCode_e'(modeReg[2:0]))
      LEN_1:    progMask = COL_W'(0);
      LEN_2:    progMask = COL_W'(1);
      LEN_4:    progMask = COL_W'(3);
      LEN_8:    progMask = COL_W'(7);
      LEN_PAGE: begin
        if (ilvBit) lenErr = 1'b1;
        else        progMask = PAGE_MASK;
      end
      default:  lenErr = 1'b1;
    endcase
  end

  assign effMask = (startIsWrite && wSingle) ? '0 : progMask;

  always_comb begin
    case (clCode)
      3'b010:  casLatency = 2'd2;
      3'b011:  casLatency = 2'd3;
      default: casLatency = 2'd0;
    endcase
  end

  assign cfgError        = lenErr;
  assign lenMask         = effMask;
  assign strb.load       = startStb;
  assign strb.step       = active && (remain != '0) && !startStb && !stopStb;
  assign strb.interleave = ilvBit && !lenErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      active  <= 1'b0;
      remain  <= '0;
    end else begin
      if (modeSetStb) modeReg <= modeOperand;
      if (startStb) begin
        active <= 1'b1;
        remain <= effMask;
      end else if (stopStb) begin
        active <= 1'b0;
      end else if (active) begin
        if (remain == '0) active <= 1'b0;
        else              remain <= remain - 1'b1;
      end
    end
  end

  assign colValid = active;
  assign colLast  = active && (remain == '0);

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);
  assert_start_gives_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> colValid);
  assert_burst_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (colLast && !startStb) |=> !colValid);
  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !startStb) |=> !colValid);
  assert_write_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && startIsWrite && wSingle) |=> colLast);
  assert_error_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && cfgError) |=> colLast);

endmodule

// File: rtl/sdram_colgen_dp.sv
module sdram_colgen_dp
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobes_t      strb,
  input  logic [COL_W-1:0] lenMask,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colAddr
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] mask;
  logic             ilv;
  logic [COL_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beatIdx <= '0;
      mask    <= '0;
      ilv     <= 1'b0;
    end else if (strb.load) begin
      baseCol <= startCol;
      beatIdx <= '0;
      mask    <= lenMask;
      ilv     <= strb.interleave;
    end else if (strb.step) begin
      beatIdx <= beatIdx + 1'b1;
    end
  end

  assign lowBits = ilv ? (baseCol ^ beatIdx) : (baseCol + beatIdx);
  assign colAddr = (baseCol & ~mask) | (lowBits & mask);

  assert_block_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> ((colAddr & ~mask) == $past(colAddr & ~mask)));
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !ilv) |=> (colAddr & mask) == (($past(colAddr) + 1'b1) & mask));

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int OP_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSetStb,
  input  logic [OP_W-1:0]  modeOperand,
  input  logic             startStb,
  input  logic             startIsWrite,
  input  logic [COL_W-1:0] startCol,
  input  logic             stopStb,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             colLast,
  output logic             cfgError,
  output logic [1:0]       casLatency
);

  colStrobes_t      strb;
  logic [COL_W-1:0] lenMask;

  sdram_colgen_ctrl #(.COL_W(COL_W), .OP_W(OP_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .modeSetStb   (modeSetStb),
    .modeOperand  (modeOperand),
    .startStb     (startStb),
    .startIsWrite (startIsWrite),
    .stopStb      (stopStb),
    .strb         (strb),
    .lenMask      (lenMask),
    .colValid     (colValid),
    .colLast      (colLast),
    .cfgError     (cfgError),
    .casLatency   (casLatency)
  );

  sdram_colgen_dp #(.COL_W(COL_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lenMask  (lenMask),
    .startCol (startCol),
    .colAddr  (colAddr)
  );

endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSetStb = 1'b0;
  logic [12:0] modeOperand = '0;
  logic        startStb = 1'b0;
  logic        startIsWrite = 1'b0;
  logic [7:0]  startCol = '0;
  logic        stopStb = 1'b0;
  logic [7:0]  colAddr;
  logic        colValid, colLast, cfgError;
  logic [1:0]  casLatency;

  int    nChecks = 0;
  int    nFails  = 0;
  int    q[$];
  int    mMode = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rstN(rstN), .modeSetStb(modeSetStb), .modeOperand(modeOperand),
    .startStb(startStb), .startIsWrite(startIsWrite), .startCol(startCol),
    .stopStb(stopStb), .colAddr(colAddr), .colValid(colValid), .colLast(colLast),
    .cfgError(cfgError), .casLatency(casLatency)
  );

  function automatic int mLen(int m, bit wr);
    int code = m & 7;
    bit ilv = ((m >> 3) & 1) != 0;
    if (wr && (((m >> 9) & 1) != 0)) return 1;
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return ilv ? 1 : 256;
      default: return 1;
    endcase
  endfunction

  function automatic bit mErr(int m);
    int code = m & 7;
    return (code >= 4 && code <= 6) || (code == 7 && ((m >> 3) & 1) != 0);
  endfunction

  function automatic int mCas(int m);
    int c = (m >> 4) & 7;
    return (c == 2) ? 2 : (c == 3) ? 3 : 0;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit expValid = q.size() > 0;
    check(colValid == expValid, "colValid", int'(colValid), int'(expValid));
    if (expValid) begin
      check(int'(colAddr) == q[0], "colAddr", int'(colAddr), q[0]);
      check(colLast == (q.size() == 1), "colLast", int'(colLast), int'(q.size() == 1));
    end
    check(cfgError == mErr(mMode), "cfgError", int'(cfgError), int'(mErr(mMode)));
    check(int'(casLatency) == mCas(mMode), "casLatency", int'(casLatency), mCas(mMode));
  endtask

  task automatic tick();
    @(posedge clk);
    if (q.size() > 0) void'(q.pop_front());
    if (stopStb) q.delete();
    if (startStb) begin
      int len = mLen(mMode, startIsWrite);
      int s = int'(startCol);
      int base = s - (s % len);
      bit ilv = ((mMode >> 3) & 1) != 0 && !mErr(mMode);
      q.delete();
      for (int i = 0; i < len; i++) begin
        if (ilv) q.push_back(base + ((s % len) ^ i));
        else     q.push_back(base + (((s % len) + i) % len));
      end
    end
    if (modeSetStb) mMode = int'(modeOperand);
    @(negedge clk);
    compareAll();
  endtask

  task automatic setMode(int op);
    modeSetStb = 1'b1; modeOperand = 13'(op);
    tick();
    modeSetStb = 1'b0;
  endtask

  task automatic begin_burst(int col, bit wr);
    startStb = 1'b1; startCol = 8'(col); startIsWrite = wr;
    tick();
    startStb = 1'b0; startIsWrite = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, 1-beat sequential burst
    curReq = "R1";
    compareAll();
    begin_burst(8'h47, 1'b0);
    idle(2);

    // R10, R2, R3: BL4 sequential CL2, wrap inside block
    curReq = "R10";
    setMode(13'h022);
    curReq = "R3";
    begin_burst(2, 1'b0);
    idle(5);
    begin_burst(8'h1E, 1'b1);
    idle(5);

    // R4: BL8 interleave CL3
    curReq = "R4";
    setMode(13'h03B);
    begin_burst(5, 1'b0);
    idle(9);
    begin_burst(8'hAD, 1'b0);
    idle(9);

    // R2: BL2 sequential, then BL1
    curReq = "R2";
    setMode(13'h021);
    begin_burst(8'h33, 1'b0);
    idle(3);
    setMode(13'h030);
    begin_burst(8'h90, 1'b0);
    idle(2);

    // R2 full page from 250, wraps past 255
    curReq = "R2";
    setMode(13'h037);
    begin_burst(250, 1'b0);
    idle(258);

    // R7: stop a full page burst and a BL8 burst
    curReq = "R7";
    begin_burst(8'h10, 1'b0);
    idle(9);
    stopStb = 1'b1; tick(); stopStb = 1'b0;
    idle(3);
    setMode(13'h033);
    begin_burst(8'h44, 1'b1);
    idle(2);
    stopStb = 1'b1; tick(); stopStb = 1'b0;
    idle(2);

    // R6: write-single with BL8 sequential
    curReq = "R6";
    setMode(13'h233);
    begin_burst(8'h6B, 1'b1);
    idle(3);
    begin_burst(8'h6B, 1'b0);
    idle(10);

    // R8: restart mid-burst, and start wins over stop
    curReq = "R8";
    setMode(13'h03B);
    begin_burst(8'h20, 1'b0);
    idle(2);
    begin_burst(8'h83, 1'b0);
    idle(3);
    stopStb = 1'b1; startStb = 1'b1; startCol = 8'h0F;
    tick();
    stopStb = 1'b0; startStb = 1'b0;
    idle(10);

    // R9: reserved length code and interleave full page
    curReq = "R9";
    setMode(13'h025);
    begin_burst(8'hC3, 1'b0);
    idle(3);
    setMode(13'h03F);
    begin_burst(8'h7E, 1'b0);
    idle(3);
    setMode(13'h032);
    begin_burst(8'h7E, 1'b0);
    idle(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule